// File: doc/BRIEF.md
# Incrementing Burst Bus Master with Selectable Error Policy

This block is a bus master for a pipelined address/data bus. It takes one command at a time from a local requester. A command gives a start address, a beat count, a transfer size and a direction. The block then runs one incrementing burst on the bus. Every beat uses an address phase followed by a data phase, and each data phase overlaps the next beat's address phase. A single slave stretches any data phase by holding `hready` low. The slave signals a failed beat with a two-cycle ERROR response on `hresp`.

Write data comes from a local source that works like the head of a FIFO. The master takes one word each time a write beat's address phase is accepted. It places the low bytes of that word on the byte lanes that the address and size select. Read data is taken from the selected lanes and moved down to the low bits. It is then handed to a local sink, but only for beats that end with an OKAY response.

A run-time input, `cfg_abort_on_err`, decides what happens after an ERROR response. The master either stops the burst or runs the remaining beats. At the end of the burst the master raises a one-cycle completion pulse. The pulse carries an error flag and the number of beats that finished OKAY.

Top module: `burst_bus_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `htrans` is IDLE (2'b00), `cmd_ready` is 1, and `done`, `rd_valid` and `wd_pop` are 0.
- R2: `htrans` is 2'b10 (NONSEQ) for the first accepted beat of a burst and 2'b11 (SEQ) for every later one. Beat k has address `cmd_addr + k * 2^cmd_size`. `hsize` equals `cmd_size` (log2 of the byte count) and `hwrite` equals `cmd_write` (1 = write).
- R3: While an active address phase is stalled by `hready` low with `hresp` at 0 (OKAY), `haddr` and `htrans` keep their values into the next cycle.
- R4: During a write data phase, `hwdata` does not change while `hready` is low.
- R5: The write word is `wd_data` placed little-endian. Its low 2^size bytes go on lanes starting at `haddr mod (DATA_W/8)`, rounded down to the size. All other lanes read zero.
- R6: `rd_valid` is 1 only in a read data phase cycle with `hready` 1 and `hresp` 0. In that cycle `rd_data` holds the selected lanes shifted down to bit 0, with zeros above. The beat that ends ERROR gives no `rd_valid`.
- R7: With `cfg_abort_on_err` at 1, `htrans` is IDLE in the second cycle of an ERROR response, and no later beat of the burst is issued.
- R8: With `cfg_abort_on_err` at 0, every beat of the burst is issued, whatever the responses.
- R9: `done` is a one-cycle pulse after the last data phase ends. `done_err` is 1 if any beat got ERROR. `done_beats` counts the beats that ended OKAY.
- R10: `cmd_ready` is 1 only while idle. A command offered during a burst is ignored and does not change the running burst.
- R11: `wd_pop` is 1 exactly in the cycles where a write beat's address phase is accepted (`hready` 1). There is one pop per issued write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle (idle) |
| cmd_addr | input | ADDR_W | Start address, aligned to the size |
| cmd_len | input | LEN_W | Beat count, 1 or more |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cfg_abort_on_err | input | 1 | 1 = stop burst after ERROR, 0 = continue |
| wd_pop | output | 1 | Write word consumed this cycle |
| wd_data | input | DATA_W | Head word of the write source |
| rd_valid | output | 1 | Read word valid for the sink |
| rd_data | output | DATA_W | Read word, aligned to bit 0 |
| done | output | 1 | Burst finished pulse |
| done_err | output | 1 | Burst saw an ERROR response |
| done_beats | output | LEN_W | Beats that ended OKAY |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hwdata | output | DATA_W | Bus write data |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Slave ready, ends the current data phase |
| hresp | input | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The assertions assume the slave follows the bus rules:
- An ERROR response is one cycle with `hready` low and `hresp` high, then one cycle with both high.
- `hresp` is 0 whenever no data phase is in progress.
- `cfg_abort_on_err` stays constant during a burst.
- Commands have a non-zero length and a size no wider than the bus.

The bench's slave model produces only such responses: wait states, then either OKAY or the two-cycle ERROR, and idle OKAY outside data phases. Its commands keep the address aligned and the length at least one. The only stray commands it offers are sent while a data phase is known to be in progress.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

endpackage

// File: rtl/bbm_lane_pack.sv
// Places the low 2^size bytes of a word onto the byte lanes picked by the
// address offset; unused lanes are zero.
module bbm_lane_pack #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               data_in,
    input  logic [$clog2(DATA_W/8)-1:0]     offset,
    input  logic [2:0]                      size,
    output logic [DATA_W-1:0]               lanes_out
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    logic [DATA_W-1:0] kept;
    logic [OFF_W-1:0]  off_al;

    assign off_al = offset & ~((OFF_W'(1) << size) - OFF_W'(1));

    for (genvar b = 0; b < NB; b++) begin : g_keep
        assign kept[8*b +: 8] = ((32'(b) >> size) == 32'd0) ? data_in[8*b +: 8] : 8'h00;
    end

    assign lanes_out = kept << {off_al, 3'b000};
endmodule

// File: rtl/bbm_lane_extract.sv
// Takes the 2^size bytes at the address offset and returns them at bit 0.
module bbm_lane_extract #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               lanes_in,
    input  logic [$clog2(DATA_W/8)-1:0]     offset,
    input  logic [2:0]                      size,
    output logic [DATA_W-1:0]               data_out
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    logic [DATA_W-1:0] shifted;
    logic [OFF_W-1:0]  off_al;

    assign off_al  = offset & ~((OFF_W'(1) << size) - OFF_W'(1));
    assign shifted = lanes_in >> {off_al, 3'b000};

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign data_out[8*b +: 8] = ((32'(b) >> size) == 32'd0) ? shifted[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [2:0]        cmd_size,
    input  logic              cmd_write,
    input  logic              cfg_abort_on_err,
    output logic              wd_pop,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              done_err,
    output logic [LEN_W-1:0]  done_beats,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    input  logic              hresp
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    typedef struct packed {
        state_t             state;
        logic [ADDR_W-1:0]  addr;       // address of the beat on the bus
        logic [LEN_W-1:0]   left;       // beats not yet accepted
        trans_t             htrans;
        logic               write;
        logic [2:0]         size;
        logic               dph;        // data phase in progress
        logic               dp_write;
        logic [OFF_W-1:0]   dp_off;
        logic [LEN_W-1:0]   ok_cnt;
        logic               err;
        logic [DATA_W-1:0]  wdata;
        logic               done;
        logic               done_err;
        logic [LEN_W-1:0]   done_beats;
    } regs_t;

    regs_t q, d;

    logic              addr_acc;
    logic              beat_end;
    logic              err_first;
    logic [DATA_W-1:0] packed_wd;
    logic [ADDR_W-1:0] next_addr;

    bbm_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .data_in   (wd_data),
        .offset    (q.addr[OFF_W-1:0]),
        .size      (q.size),
        .lanes_out (packed_wd)
    );

    bbm_lane_extract #(.DATA_W(DATA_W)) u_extract (
        .lanes_in (hrdata),
        .offset   (q.dp_off),
        .size     (q.size),
        .data_out (rd_data)
    );

    assign next_addr = q.addr + (ADDR_W'(1) << q.size);
    assign addr_acc  = (q.state == ST_RUN) && (q.htrans != TR_IDLE) && hready;
    assign beat_end  = q.dph && hready;
    assign err_first = q.dph && !hready && hresp;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.state == ST_IDLE) begin
            if (cmd_valid) begin
                d.state  = ST_RUN;
                d.addr   = cmd_addr;
                d.left   = cmd_len;
                d.htrans = TR_NONSEQ;
                d.write  = cmd_write;
                d.size   = cmd_size;
                d.dph    = 1'b0;
                d.ok_cnt = '0;
                d.err    = 1'b0;
            end
        end else begin
            if (beat_end) begin
                d.dph = 1'b0;
                if (hresp) d.err    = 1'b1;
                else       d.ok_cnt = q.ok_cnt + LEN_W'(1);
            end
            if (addr_acc) begin
                d.dph      = 1'b1;
                d.dp_write = q.write;
                d.dp_off   = q.addr[OFF_W-1:0];
                if (q.write) d.wdata = packed_wd;
                d.left     = q.left - LEN_W'(1);
                if (q.left > LEN_W'(1)) begin
                    d.htrans = TR_SEQ;
                    d.addr   = next_addr;
                end else begin
                    d.htrans = TR_IDLE;
                end
            end
            if (err_first && cfg_abort_on_err) begin
                d.htrans = TR_IDLE;
                d.left   = '0;
            end
            if (!d.dph && (d.htrans == TR_IDLE)) begin
                d.state      = ST_IDLE;
                d.done       = 1'b1;
                d.done_err   = d.err;
                d.done_beats = d.ok_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_ready  = (q.state == ST_IDLE);
    assign wd_pop     = addr_acc && q.write;
    assign rd_valid   = q.dph && !q.dp_write && hready && !hresp;
    assign done       = q.done;
    assign done_err   = q.done_err;
    assign done_beats = q.done_beats;
    assign haddr      = q.addr;
    assign htrans     = q.htrans;
    assign hwrite     = q.write;
    assign hsize      = q.size;
    assign hwdata     = q.wdata;
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_abort_on_err,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic              hwrite,
    input logic [2:0]        hsize,
    input logic [DATA_W-1:0] hwdata,
    input logic              hready,
    input logic              hresp,
    input logic              rd_valid,
    input logic              done
);
    // data phase tracked from bus ports alone
    logic dph, dwr;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dph <= 1'b0;
            dwr <= 1'b0;
        end else if (hready) begin
            dph <= (htrans != 2'b00);
            dwr <= hwrite;
        end
    end

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && hready) |=>
        (htrans != 2'b11 || haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize))));

    a_r2_first_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b00) |=> (htrans != 2'b11));

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00 && !hready && !hresp) |=>
        (haddr == $past(haddr) && htrans == $past(htrans)));

    a_r4_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dph && dwr && !hready) |=> $stable(hwdata));

    a_r6_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (hready && !hresp && dph && !dwr));

    a_r7_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_abort_on_err && dph && hresp && !hready) |=> (htrans == 2'b00));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (htrans == 2'b00 && cmd_ready));

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (htrans == 2'b00));
endmodule

bind burst_bus_master bbm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_abort_on_err (cfg_abort_on_err),
    .cmd_ready        (cmd_ready),
    .haddr            (haddr),
    .htrans           (htrans),
    .hwrite           (hwrite),
    .hsize            (hsize),
    .hwdata           (hwdata),
    .hready           (hready),
    .hresp            (hresp),
    .rd_valid         (rd_valid),
    .done             (done)
);

// File: tb/burst_bus_master_tb.sv
module burst_bus_master_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cfg_abort_on_err = 1'b0;
    logic [AW-1:0] cmd_addr = '0, haddr;
    logic [LW-1:0] cmd_len = '0, done_beats;
    logic [2:0]    cmd_size = '0, hsize;
    logic          wd_pop, rd_valid, done, done_err, hwrite;
    logic [DW-1:0] wd_data = '0, rd_data, hwdata, hrdata = '0;
    logic [1:0]    htrans;
    logic          hready = 1'b1, hresp = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    burst_bus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_write(cmd_write),
        .cfg_abort_on_err(cfg_abort_on_err), .wd_pop(wd_pop), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err),
        .done_beats(done_beats), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wr_word(input int tid, input int k);
        return 32'h3C5A_0F96 ^ (32'(tid) << 20) ^ (32'(k) * 32'h0103_0507);
    endfunction

    function automatic logic [31:0] rd_word(input int tid, input int k);
        return 32'hC0DE_4B21 ^ (32'(tid) << 8) ^ (32'(k) * 32'h1111_1111);
    endfunction

    function automatic logic [31:0] lanes_of(input logic [31:0] w, input logic [31:0] a, input int sz);
        logic [31:0] r = '0;
        int nb  = 1 << sz;
        int off = ((a % 4) / nb) * nb;
        for (int b = 0; b < nb; b++) r[8*(off+b) +: 8] = w[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] from_lanes(input logic [31:0] bus, input logic [31:0] a, input int sz);
        logic [31:0] r = '0;
        int nb  = 1 << sz;
        int off = ((a % 4) / nb) * nb;
        for (int b = 0; b < nb; b++) r[8*b +: 8] = bus[8*(off+b) +: 8];
        return r;
    endfunction

    task automatic run_burst(input int tid, input logic [31:0] base, input int len, input int sz,
                             input bit wr, input bit abort, input int waits, input int eb, input bit stress);
        int issued = 0, pops = 0, cyc = 0, dbeat = 0, wleft = 0, es = 0;
        bit dph = 0, got_done = 0, prev_stall = 0, prev_wwait = 0;
        logic [31:0] dadr = '0, prev_addr = '0, prev_wd = '0;
        logic [1:0]  prev_tr = '0;
        int exp_issued = (abort && eb >= 0) ? eb + 1 : len;
        int exp_ok     = exp_issued - ((eb >= 0) ? 1 : 0);
        cfg_abort_on_err = abort;
        while (!got_done && cyc < 400) begin
            @(negedge clk);
            if (cyc == 0) begin
                cmd_valid = 1'b1; cmd_addr = base; cmd_len = LW'(len);
                cmd_size = 3'(sz); cmd_write = wr;
            end else if (stress && dph) begin
                cmd_valid = 1'b1; cmd_addr = 32'hDEAD_0000; cmd_len = 5'd7;
                cmd_size = 3'd0; cmd_write = ~wr;
            end else begin
                cmd_valid = 1'b0;
            end
            wd_data = wr_word(tid, pops);
            if (dph) begin
                hrdata = rd_word(tid, dbeat);
                if (dbeat == eb) {hready, hresp} = (es == 0) ? 2'b01 : 2'b11;
                else if (wleft > 0) {hready, hresp} = 2'b00;
                else {hready, hresp} = 2'b10;
            end else begin
                hrdata = 32'hFFFF_FFFF;
                {hready, hresp} = 2'b10;
            end
            #1;
            if (cyc == 0) chk(cmd_ready == 1'b1, "R10 ready when idle", cmd_ready, 1);
            else if (cmd_valid) chk(cmd_ready == 1'b0, "R10 busy ignores command", cmd_ready, 0);
            // data phase
            if (dph && hready && !hresp) begin
                if (wr) chk(hwdata == lanes_of(wr_word(tid, dbeat), dadr, sz), "R5 write lanes",
                            hwdata, lanes_of(wr_word(tid, dbeat), dadr, sz));
                else chk(rd_valid && rd_data == from_lanes(rd_word(tid, dbeat), dadr, sz), "R6 read data",
                         {rd_valid, rd_data}, {1'b1, from_lanes(rd_word(tid, dbeat), dadr, sz)});
            end else begin
                chk(rd_valid == 1'b0, "R6 no read strobe", rd_valid, 0);
            end
            if (prev_wwait) chk(hwdata == prev_wd, "R4 write data held", hwdata, prev_wd);
            if (abort && dph && hresp && hready) chk(htrans == 2'b00, "R7 idle in 2nd error cycle", htrans, 0);
            // address phase
            if (prev_stall) chk(haddr == prev_addr && htrans == prev_tr, "R3 address held",
                                {htrans, haddr}, {prev_tr, prev_addr});
            if (htrans != 2'b00 && hready) begin
                chk(haddr == base + 32'(issued * (1 << sz)) && htrans == ((issued == 0) ? 2'b10 : 2'b11)
                    && hwrite == wr && hsize == 3'(sz), "R2 beat address and type",
                    {htrans, haddr}, {((issued == 0) ? 2'b10 : 2'b11), base + 32'(issued * (1 << sz))});
                chk(wd_pop == wr, "R11 pop per write beat", wd_pop, wr);
                issued++;
            end else begin
                chk(wd_pop == 1'b0, "R11 no pop", wd_pop, 0);
            end
            if (done) begin
                got_done = 1;
                chk(done_err == (eb >= 0), "R9 error flag", done_err, (eb >= 0));
                chk(done_beats == LW'(exp_ok), "R9 beat count", done_beats, exp_ok);
                if (abort) chk(issued == exp_issued, "R7 beats issued", issued, exp_issued);
                else       chk(issued == exp_issued, "R8 beats issued", issued, exp_issued);
                chk(pops == (wr ? exp_issued : 0), "R11 total pops", pops, wr ? exp_issued : 0);
            end
            // advance model across the coming edge
            prev_stall = (htrans != 2'b00) && !hready && !hresp;
            prev_addr  = haddr;
            prev_tr    = htrans;
            prev_wwait = dph && wr && !hready;
            prev_wd    = hwdata;
            if (wd_pop) pops++;
            if (dph && hready) dph = 0;
            else if (dph) begin
                if (dbeat == eb) es = 1;
                else if (wleft > 0) wleft--;
            end
            if (htrans != 2'b00 && hready) begin
                dph = 1; dbeat = issued - 1; dadr = haddr; wleft = waits; es = 0;
            end
            cyc++;
        end
        chk(got_done, "R9 burst completes", got_done, 1);
        cmd_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            {hready, hresp} = 2'b10;
            #1;
            chk(done == 1'b0 && htrans == 2'b00 && cmd_ready == 1'b1, "R9 single pulse then idle",
                {done, htrans, cmd_ready}, 4'b0001);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(htrans == 2'b00 && cmd_ready && !done && !rd_valid && !wd_pop, "R1 reset state",
            {htrans, cmd_ready, done, rd_valid, wd_pop}, 6'b001000);
        @(negedge clk);
        rst_n = 1'b1;
        //        tid base          len sz wr ab wt eb  st
        run_burst(1, 32'h0000_0100, 4, 2, 1, 0, 0, -1, 0);
        run_burst(2, 32'h0000_0200, 4, 2, 0, 0, 2, -1, 0);
        run_burst(3, 32'h0000_0301, 6, 0, 1, 0, 1, -1, 0);
        run_burst(4, 32'h0000_0402, 3, 1, 0, 0, 0, -1, 0);
        run_burst(5, 32'h0000_0500, 5, 2, 1, 1, 0, 2, 0);
        run_burst(6, 32'h0000_0600, 5, 2, 1, 0, 1, 2, 0);
        run_burst(7, 32'h0000_0700, 4, 2, 0, 1, 1, 1, 0);
        run_burst(8, 32'h0000_0800, 4, 2, 0, 0, 0, 3, 0);
        run_burst(9, 32'h0000_0900, 1, 2, 0, 1, 0, 0, 0);
        run_burst(10, 32'h0000_0A02, 8, 1, 1, 0, 2, -1, 1);
        run_burst(11, 32'h0000_0B03, 5, 0, 0, 1, 1, 3, 1);
        // reset in the middle of a burst
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 32'h0000_0C00; cmd_len = 5'd6; cmd_size = 3'd2; cmd_write = 1'b1;
        {hready, hresp} = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(htrans == 2'b00 && cmd_ready && !done && !wd_pop, "R1 reset mid burst",
            {htrans, cmd_ready, done, wd_pop}, 5'b00100);
        rst_n = 1'b1;
        {hready, hresp} = 2'b10;
        run_burst(12, 32'h0000_0D00, 2, 2, 1, 0, 0, -1, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule